// File: doc/BRIEF.md
# Magic-Key Watchdog Timer

This block is a bus-mapped watchdog. Once software arms it, it counts pulses of a tick-enable input. If software does not service it within a period of 2^(d+1) ticks, it raises a one-cycle reset request. The exponent d comes from a 5-bit delay field. Servicing is deliberately awkward. Software writes one fixed 32-bit key to the first key register, then a second, different key to the second key register. Any other value, or the second key without the first, counts as a fault and also raises the reset request.

A 3-bit cause code records which event last asked for a reset. A software-reset register, an external user-reset input, expiry and faulty servicing each set their own code. The cause code lives in the power-on domain. A system (warm) reset clears the configuration and the counter but leaves the cause readable, so software can learn after reboot why the chip was reset.

Stopping is also guarded. Clearing the enable bit only takes effect once a full valid service sequence has been written after it.

Service checker states:

- `SVC_IDLE`: waiting for the first key.
- `SVC_ARMED`: the first key has been accepted.

Transitions:

- `SVC_IDLE`→`SVC_ARMED` when the correct first key is written.
- `SVC_ARMED`→`SVC_IDLE` when the correct second key is written; this is a valid service.
- Any wrong key write in either state returns the checker to `SVC_IDLE` and flags a fault.
- Writes to other registers leave the state unchanged.

Top module: `wdog_magic_top`

## Requirements
- R1: After power-on reset, `rst_req` is 0, the cause code reads 0 (hard reset), the configuration reads 0, and ticks cause no expiry.
- R2: The configuration register at offset 0x4 holds the enable in bit 31 and the delay d in bits 4:0. A read returns those fields with all other bits zero.
- R3: While counting with delay d, the 2^(d+1)-th tick pulses `rst_req` high for exactly one cycle, sets cause code 1 and restarts the count. Clock cycles without `tick` are not counted.
- R4: Writing 0xABCD1234 to offset 0x8 and then 0x4321DCBA to offset 0xC is a valid service. It restarts the count from zero.
- R5: Any of the following is a fault: a wrong value written to offset 0x8 or 0xC, or a write to 0xC not preceded by the correct first key. A fault pulses `rst_req` and sets cause code 2.
- R6: Clearing the enable bit does not stop counting. Counting stops at the first valid service after the bit is cleared.
- R7: A delay written while counting is used only from the next restart, whether that restart comes from expiry or from a service.
- R8: A write of any value to offset 0x0 pulses `rst_req` and sets cause code 3.
- R9: A high `user_rst` sets cause code 4 without raising `rst_req`.
- R10: A read of offset 0x8 returns the cause code in bits 2:0. `sys_rst_n` clears the configuration and stops counting but keeps the cause code. Only `por_n` sets the cause code to 0.
- R11: When events coincide, the cause recorded follows this priority: user reset first, then bus events (fault or software reset), then expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the cause code |
| sys_rst_n | input | 1 | Warm reset, active low; clears all state except the cause code |
| tick | input | 1 | Watchdog count enable |
| user_rst | input | 1 | External user-reset indication |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en`, zero otherwise |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The timeout is swept over delays 0 to 5 with back-to-back ticks, which separates an off-by-one in the period from a wrong exponent. The sweep also runs a second period to show the count restarts. A run with ticks on alternating cycles distinguishes counting ticks from counting clocks.

Service sequences are tried in several forms: correct, wrong first key, wrong second key, second key alone, and keys swapped between registers. Each form is preceded by a software reset, so the cause code visibly changes from 3. Coincident user-reset and expiry, and a fault in the same cycle as expiry, pin down the priority order. Warm and power-on resets are then applied to a set cause code to separate the two reset domains.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 32;
    localparam int EN_BIT = 31;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'hABCD_1234;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h4321_DCBA;

    typedef enum logic [2:0] {
        CAUSE_HARD   = 3'd0,
        CAUSE_EXPIRE = 3'd1,
        CAUSE_BADSVC = 3'd2,
        CAUSE_SOFT   = 3'd3,
        CAUSE_USER   = 3'd4
    } cause_e;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             wr_en_val,
    input  logic [DLY_W-1:0] wr_dly_val,
    output logic             cfg_en,
    output logic [DLY_W-1:0] cfg_dly
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en  <= 1'b0;
            cfg_dly <= '0;
        end else if (cfg_wr) begin
            cfg_en  <= wr_en_val;
            cfg_dly <= wr_dly_val;
        end
    end
endmodule

// File: rtl/wdog_svc_fsm.sv
module wdog_svc_fsm
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key1_wr,
    input  logic              key2_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              svc_ok,
    output logic              svc_bad
);
    svc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        svc_ok  = 1'b0;
        svc_bad = 1'b0;
        unique case (state_q)
            SVC_IDLE: begin
                if (key1_wr) begin
                    if (wdata == KEY_FIRST) state_d = SVC_ARMED;
                    else                    svc_bad = 1'b1;
                end else if (key2_wr) begin
                    svc_bad = 1'b1;
                end
            end
            SVC_ARMED: begin
                if (key1_wr) begin
                    if (wdata != KEY_FIRST) begin
                        svc_bad = 1'b1;
                        state_d = SVC_IDLE;
                    end
                end else if (key2_wr) begin
                    state_d = SVC_IDLE;
                    if (wdata == KEY_SECOND) svc_ok  = 1'b1;
                    else                     svc_bad = 1'b1;
                end
            end
            default: state_d = SVC_IDLE;
        endcase
    end

    p_ok_from_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |-> (state_q == SVC_ARMED && key2_wr));
    p_bad_returns_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_bad |=> (state_q == SVC_IDLE));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_wr,
    input  logic             wr_en_val,
    input  logic [DLY_W-1:0] wr_dly_val,
    input  logic             cfg_en,
    input  logic [DLY_W-1:0] cfg_dly,
    input  logic             svc_ok,
    output logic             expire
);
    localparam int CNT_W = (1 << DLY_W) + 1;

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DLY_W-1:0] dly_act_q;
    logic [CNT_W-1:0] lim;
    logic             start;

    assign lim    = CNT_W'(1) << (32'(dly_act_q) + 32'd1);
    assign start  = cfg_wr && wr_en_val && !run_q;
    assign expire = run_q && tick && !svc_ok && (cnt_q == lim - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            cnt_q     <= '0;
            dly_act_q <= '0;
        end else if (svc_ok) begin
            if (!cfg_en) run_q <= 1'b0;
            cnt_q     <= '0;
            dly_act_q <= cfg_dly;
        end else if (start) begin
            run_q     <= 1'b1;
            cnt_q     <= '0;
            dly_act_q <= wr_dly_val;
        end else if (expire) begin
            cnt_q     <= '0;
            dly_act_q <= cfg_dly;
        end else if (run_q && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < lim));
    p_reload_on_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> (cnt_q == '0));
    p_stop_needs_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(svc_ok && !cfg_en));
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   user_rst,
    input  logic   svc_bad,
    input  logic   soft_wr,
    input  logic   expire,
    output cause_e cause_q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        cause_q <= CAUSE_HARD;
        else if (user_rst) cause_q <= CAUSE_USER;
        else if (svc_bad)  cause_q <= CAUSE_BADSVC;
        else if (soft_wr)  cause_q <= CAUSE_SOFT;
        else if (expire)   cause_q <= CAUSE_EXPIRE;
    end

    p_cause_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        !(user_rst || svc_bad || soft_wr || expire) |=> $stable(cause_q));
    p_user_wins_r11: assert property (@(posedge clk) disable iff (!por_n)
        user_rst |=> (cause_q == CAUSE_USER));
endmodule

// File: rtl/wdog_magic_top.sv
module wdog_magic_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DLY_W  = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              tick,
    input  logic              user_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    localparam logic [ADDR_W-1:0] OFS_SOFT = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] OFS_KEY1 = ADDR_W'(4'h8);
    localparam logic [ADDR_W-1:0] OFS_KEY2 = ADDR_W'(4'hC);

    logic             rst_n;
    logic             soft_wr, cfg_wr, key1_wr, key2_wr;
    logic             cfg_en;
    logic [DLY_W-1:0] cfg_dly;
    logic             svc_ok, svc_bad, expire;
    cause_e           cause_q;

    assign rst_n   = por_n && sys_rst_n;
    assign soft_wr = wr_en && (addr == OFS_SOFT);
    assign cfg_wr  = wr_en && (addr == OFS_CFG);
    assign key1_wr = wr_en && (addr == OFS_KEY1);
    assign key2_wr = wr_en && (addr == OFS_KEY2);

    wdog_cfg #(.DLY_W(DLY_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .wr_en_val  (wdata[EN_BIT]),
        .wr_dly_val (wdata[DLY_W-1:0]),
        .cfg_en     (cfg_en),
        .cfg_dly    (cfg_dly)
    );

    wdog_svc_fsm u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .key1_wr (key1_wr),
        .key2_wr (key2_wr),
        .wdata   (wdata),
        .svc_ok  (svc_ok),
        .svc_bad (svc_bad)
    );

    wdog_counter #(.DLY_W(DLY_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cfg_wr     (cfg_wr),
        .wr_en_val  (wdata[EN_BIT]),
        .wr_dly_val (wdata[DLY_W-1:0]),
        .cfg_en     (cfg_en),
        .cfg_dly    (cfg_dly),
        .svc_ok     (svc_ok),
        .expire     (expire)
    );

    wdog_cause u_cause (
        .clk      (clk),
        .por_n    (por_n),
        .user_rst (user_rst),
        .svc_bad  (svc_bad),
        .soft_wr  (soft_wr),
        .expire   (expire),
        .cause_q  (cause_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire || svc_bad || soft_wr;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == OFS_CFG) begin
                rdata[EN_BIT]    = cfg_en;
                rdata[DLY_W-1:0] = cfg_dly;
            end else if (addr == OFS_KEY1) begin
                rdata[2:0] = cause_q;
            end
        end
    end

    p_req_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(expire || svc_bad || soft_wr));
    p_bad_requests_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc_bad |=> rst_req);
endmodule

// File: tb/test_wdog_magic_top.sv
module test_wdog_magic_top;
    localparam int  PERIOD = 10;
    localparam logic [31:0] K1 = 32'hABCD_1234;
    localparam logic [31:0] K2 = 32'h4321_DCBA;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        tick = 1'b0;
    logic        user_rst = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    wdog_magic_top i_wdog_magic_top (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick),
        .user_rst(user_rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .rst_req(rst_req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n, output int pulses);
        pulses = 0;
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            step();
            if (rst_req) pulses++;
        end
        tick = 1'b0;
    endtask

    task automatic gticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); if (rst_req) pulses++;
            tick = 1'b0; step(); if (rst_req) pulses++;
        end
    endtask

    task automatic sysrst();
        sys_rst_n = 1'b0; step(); step(); sys_rst_n = 1'b1; step();
    endtask

    task automatic service();
        wr(4'h8, K1);
        wr(4'hC, K2);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p;
        step(); step(); por_n = 1'b1; step();

        // R1 reset state
        chk("R1 rst_req", {31'b0, rst_req}, 32'd0);
        rd(4'h8, v); chk("R1 cause", v, 32'd0);
        rd(4'h4, v); chk("R1 cfg", v, 32'd0);
        ticks(100, p); chk("R1 no expiry when idle", p, 0);

        // R2 config fields
        wr(4'h4, 32'h7FFF_FFE3);
        rd(4'h4, v); chk("R2 cfg readback", v, 32'h0000_0003);
        ticks(20, p); chk("R2 disabled no expiry", p, 0);
        sysrst();

        // R3 delay sweep, R8 soft reset before each
        for (int d = 0; d < 6; d++) begin
            int lim;
            lim = 1 << (d + 1);
            wr(4'h0, 32'h5A5A_0000 | d);
            chk("R8 soft rst_req", {31'b0, rst_req}, 32'd1);
            rd(4'h8, v); chk("R8 cause soft", v, 32'd3);
            step(); chk("R8 pulse one cycle", {31'b0, rst_req}, 32'd0);
            sysrst();
            wr(4'h4, 32'h8000_0000 | d);
            ticks(lim - 1, p); chk("R3 early", p, 0);
            ticks(1, p); chk("R3 expiry", p, 1);
            rd(4'h8, v); chk("R3 cause expire", v, 32'd1);
            step(); chk("R3 pulse one cycle", {31'b0, rst_req}, 32'd0);
            ticks(lim - 1, p); chk("R3 restart early", p, 0);
            ticks(1, p); chk("R3 restart expiry", p, 1);
            sysrst();
        end

        // R3 gapped ticks count ticks, not clocks
        wr(4'h4, 32'h8000_0002);
        gticks(7, p); chk("R3 gapped early", p, 0);
        gticks(1, p); chk("R3 gapped expiry", p, 1);
        sysrst();

        // R4 valid service restarts count
        wr(4'h4, 32'h8000_0001);
        ticks(3, p); chk("R4 before service", p, 0);
        service();
        chk("R4 no req on service", {31'b0, rst_req}, 32'd0);
        ticks(3, p); chk("R4 after service early", p, 0);
        ticks(1, p); chk("R4 after service expiry", p, 1);
        sysrst();

        // R5 faulty service variants
        wr(4'h0, 0); wr(4'h8, 32'hABCD_1235);
        chk("R5 bad key1 req", {31'b0, rst_req}, 32'd1);
        rd(4'h8, v); chk("R5 bad key1 cause", v, 32'd2);
        wr(4'h0, 0); wr(4'hC, K2);
        chk("R5 key2 alone req", {31'b0, rst_req}, 32'd1);
        rd(4'h8, v); chk("R5 key2 alone cause", v, 32'd2);
        wr(4'h0, 0); wr(4'h8, K1);
        chk("R5 good key1 no req", {31'b0, rst_req}, 32'd0);
        wr(4'hC, 32'h4321_DCBB);
        chk("R5 bad key2 req", {31'b0, rst_req}, 32'd1);
        rd(4'h8, v); chk("R5 bad key2 cause", v, 32'd2);
        wr(4'h0, 0); wr(4'h8, K2);
        chk("R5 swapped key req", {31'b0, rst_req}, 32'd1);
        rd(4'h8, v); chk("R5 swapped key cause", v, 32'd2);
        sysrst();

        // R6 disable needs service
        wr(4'h4, 32'h8000_0001);
        wr(4'h4, 32'h0000_0001);
        rd(4'h4, v); chk("R6 cfg disabled", v, 32'd1);
        ticks(3, p); chk("R6 still counting early", p, 0);
        ticks(1, p); chk("R6 still counting expiry", p, 1);
        service();
        ticks(40, p); chk("R6 stopped after service", p, 0);
        sysrst();

        // R7 delay change applies from next restart
        wr(4'h4, 32'h8000_0001);
        ticks(2, p);
        wr(4'h4, 32'h8000_0003);
        ticks(1, p); chk("R7 old delay early", p, 0);
        ticks(1, p); chk("R7 old delay expiry", p, 1);
        ticks(15, p); chk("R7 new delay early", p, 0);
        ticks(1, p); chk("R7 new delay expiry", p, 1);
        wr(4'h4, 32'h8000_0000);
        service();
        ticks(1, p); chk("R7 service reload early", p, 0);
        ticks(1, p); chk("R7 service reload expiry", p, 1);
        sysrst();

        // R9 user reset
        wr(4'h0, 0);
        user_rst = 1'b1; step(); user_rst = 1'b0;
        chk("R9 no req", {31'b0, rst_req}, 32'd0);
        rd(4'h8, v); chk("R9 cause user", v, 32'd4);
        sysrst();

        // R11 priority
        wr(4'h4, 32'h8000_0000);
        ticks(1, p);
        tick = 1'b1; user_rst = 1'b1; step(); tick = 1'b0; user_rst = 1'b0;
        chk("R11 expiry still requests", {31'b0, rst_req}, 32'd1);
        rd(4'h8, v); chk("R11 user over expiry", v, 32'd4);
        ticks(1, p);
        tick = 1'b1; wr(4'h8, 32'h0); tick = 1'b0;
        rd(4'h8, v); chk("R11 fault over expiry", v, 32'd2);

        // R10 reset domains
        sysrst();
        rd(4'h8, v); chk("R10 cause kept on warm reset", v, 32'd2);
        rd(4'h4, v); chk("R10 cfg cleared", v, 32'd0);
        ticks(10, p); chk("R10 stopped by warm reset", p, 0);
        por_n = 1'b0; step(); por_n = 1'b1; step();
        rd(4'h8, v); chk("R10 cause cleared by power-on", v, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule